// File: doc/BRIEF.md
# Scoreboard-Managed Operation Unit Controller

This block is the control front-end between an instruction scoreboard and one single-cycle execution unit. An issue pulse, sent while the unit is idle, latches an operation code and raises one read-request bit for each source operand. The scoreboard answers each request with its own grant bit. On that grant the unit captures the matching source value. When every operand has been captured, the unit executes for one cycle. It then raises a write request and holds the result steady until the scoreboard grants the write.

The write grant places the result on the result bus for that one cycle and returns the unit to idle. A cancel input aborts the operation at any stage. It clears every pending request and the busy flag on the next clock edge. The execution path here is a small add/subtract/pass unit, so the handshake can be exercised end to end.

Top module: `opunit_ctrl`

## Requirements
- R1: After reset, `rd_req_o`, `wr_req_o`, `busy_o` and `bus_o` are all zero. `rd_req_o` stays zero until an issue has been accepted.
- R2: An issue is accepted when all of the following hold: `issue_i` is high, the unit is idle, `cancel_i` is low, no read request is pending, and none was pending in the previous cycle. On the next cycle `busy_o` is 1 and `rd_req_o` is all ones. Any other issue is ignored and leaves the operation in flight unchanged.
- R3: A raised read-request bit stays high until its own grant bit is seen or cancel is seen.
- R4: A grant bit i seen while request bit i is high clears request bit i on the next cycle and leaves the other bits unchanged. Grant bits with no matching pending request have no effect.
- R5: Operand i (bit i of the request vector; bit 0 is operand A, from `src_i[DW-1:0]`, and bit 1 is operand B, from `src_i[2*DW-1:DW]`) is captured from `src_i` in the cycle its grant is taken. Later changes to `src_i` have no effect on it.
- R6: Execution takes the cycle after the last operand is captured. On the cycle after that, `wr_req_o` is 1 and `wr_data_o` holds the result. The result for each opcode is: 0 gives A+B, 1 gives A-B, 2 gives A, and 3 gives B, all modulo 2^DW.
- R7: While `wr_req_o` is high and neither a write grant nor cancel is seen, `wr_data_o` is stable and the request stays high.
- R8: `wr_gnt_i` seen while `wr_req_o` is high (and no cancel) puts `wr_data_o` on `bus_o` in that same cycle. On the next cycle `wr_req_o` and `busy_o` are 0. In every other cycle `bus_o` is zero.
- R9: `cancel_i` makes `rd_req_o`, `wr_req_o` and `busy_o` zero on the next cycle. Cancel takes priority over issue and over both grants in the same cycle.
- R10: `wr_gnt_i` with no write request pending is ignored: `bus_o` stays zero and the state is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue_i | input | 1 | Issue pulse from the scoreboard |
| op_i | input | 2 | Operation code, sampled on an accepted issue |
| src_i | input | NSRC*DW | Source operand values, operand i in slice i |
| rd_gnt_i | input | NSRC | Per-operand read grants |
| wr_gnt_i | input | 1 | Write grant |
| cancel_i | input | 1 | Abort the operation in flight |
| busy_o | output | 1 | Operation in flight |
| rd_req_o | output | NSRC | Per-operand read requests |
| wr_req_o | output | 1 | Write request |
| wr_data_o | output | DW | Held result |
| bus_o | output | DW | Result bus, driven during a granted write |

## Verification
The hardest case to reach is the issue refused only because a read request was pending one cycle earlier. No read request is visible at the ports in that cycle, so the unit looks idle. The stimulus gets there by cancelling during the read phase and presenting a new issue on the very next cycle. The bench then checks that the issue is dropped and that the issue on the following cycle is accepted. A second hard case is a masked grant: an all-ones grant while only one request is pending. The bench checks it by changing the other operand's source value at the same moment, so any wrong recapture would show in the result.

// File: rtl/opunit_pkg.sv
package opunit_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_EXEC  = 2'd2,
    ST_WRITE = 2'd3
  } cu_state_e;

  localparam int OPW = 2;

  typedef enum logic [OPW-1:0] {
    OP_ADD    = 2'd0,
    OP_SUB    = 2'd1,
    OP_PASS_A = 2'd2,
    OP_PASS_B = 2'd3
  } cu_op_e;
endpackage

// File: rtl/opunit_seq.sv
module opunit_seq
  import opunit_pkg::*;
#(
  parameter int NSRC = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            issue_i,
  input  logic            cancel_i,
  input  logic            wr_gnt_i,
  input  logic [NSRC-1:0] rd_pend,
  input  logic [NSRC-1:0] rd_left,
  output logic            issue_take,
  output logic            exec_go,
  output logic            wr_take,
  output logic            wr_req,
  output logic            busy
);
  cu_state_e state_q, state_d;
  logic      pend_prev_q;
  logic      last_take;

  // previous-cycle memory of any pending read, used to gate issue
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_prev_q <= 1'b0;
    else        pend_prev_q <= |rd_pend;
  end

  assign issue_take = issue_i && (state_q == ST_IDLE) && !cancel_i &&
                      (rd_pend == '0) && !pend_prev_q;
  assign last_take  = (state_q == ST_READ) && (rd_left == '0) && !cancel_i;
  assign exec_go    = (state_q == ST_EXEC);
  assign wr_take    = (state_q == ST_WRITE) && wr_gnt_i && !cancel_i;

  always_comb begin
    state_d = state_q;
    if (cancel_i) begin
      state_d = ST_IDLE;
    end else begin
      case (state_q)
        ST_IDLE:  if (issue_take) state_d = ST_READ;
        ST_READ:  if (last_take)  state_d = ST_EXEC;
        ST_EXEC:  state_d = ST_WRITE;
        ST_WRITE: if (wr_take)    state_d = ST_IDLE;
        default:  state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign wr_req = (state_q == ST_WRITE);
  assign busy   = (state_q != ST_IDLE);
endmodule

// File: rtl/opunit_rdport.sv
module opunit_rdport #(
  parameter int NSRC = 2,
  parameter int DW   = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               arm,
  input  logic               cancel_i,
  input  logic [NSRC-1:0]    rd_gnt_i,
  input  logic [NSRC*DW-1:0] src_i,
  output logic [NSRC-1:0]    rd_req,
  output logic [NSRC-1:0]    rd_left,
  output logic [NSRC-1:0]    rd_take,
  output logic [NSRC*DW-1:0] opnd
);
  for (genvar gi = 0; gi < NSRC; gi++) begin : g_port
    logic          req_q;
    logic [DW-1:0] val_q;

    // a grant only counts against its own pending request
    assign rd_take[gi] = req_q && rd_gnt_i[gi];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            req_q <= 1'b0;
      else if (cancel_i)     req_q <= 1'b0;
      else if (arm)          req_q <= 1'b1;
      else if (rd_take[gi])  req_q <= 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           val_q <= '0;
      else if (rd_take[gi]) val_q <= src_i[gi*DW +: DW];
    end

    assign rd_req[gi]           = req_q;
    assign rd_left[gi]          = req_q && !rd_take[gi];
    assign opnd[gi*DW +: DW]    = val_q;
  end
endmodule

// File: rtl/opunit_alu.sv
module opunit_alu
  import opunit_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            op_load,
  input  logic [OPW-1:0]  op_i,
  input  logic            exec_go,
  input  logic [DW-1:0]   opnd_a,
  input  logic [DW-1:0]   opnd_b,
  output logic [DW-1:0]   result
);
  logic [OPW-1:0] op_q;
  logic [DW-1:0]  res_q;

  function automatic logic [DW-1:0] f_eval(input cu_op_e op,
                                           input logic [DW-1:0] a,
                                           input logic [DW-1:0] b);
    case (op)
      OP_ADD:    return a + b;
      OP_SUB:    return a - b;
      OP_PASS_A: return a;
      default:   return b;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       op_q <= '0;
    else if (op_load) op_q <= op_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       res_q <= '0;
    else if (exec_go) res_q <= f_eval(cu_op_e'(op_q), opnd_a, opnd_b);
  end

  assign result = res_q;
endmodule

// File: rtl/opunit_ctrl.sv
module opunit_ctrl
  import opunit_pkg::*;
#(
  parameter int NSRC = 2,
  parameter int DW   = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               issue_i,
  input  logic [OPW-1:0]     op_i,
  input  logic [NSRC*DW-1:0] src_i,
  input  logic [NSRC-1:0]    rd_gnt_i,
  input  logic               wr_gnt_i,
  input  logic               cancel_i,
  output logic               busy_o,
  output logic [NSRC-1:0]    rd_req_o,
  output logic               wr_req_o,
  output logic [DW-1:0]      wr_data_o,
  output logic [DW-1:0]      bus_o
);
  // named internal events, observed by the bound checker
  logic               issue_take;
  logic               exec_go;
  logic               wr_take;
  logic [NSRC-1:0]    rd_left;
  logic [NSRC-1:0]    rd_take;
  logic [NSRC*DW-1:0] opnd;

  opunit_seq #(.NSRC(NSRC)) seq_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .issue_i    (issue_i),
    .cancel_i   (cancel_i),
    .wr_gnt_i   (wr_gnt_i),
    .rd_pend    (rd_req_o),
    .rd_left    (rd_left),
    .issue_take (issue_take),
    .exec_go    (exec_go),
    .wr_take    (wr_take),
    .wr_req     (wr_req_o),
    .busy       (busy_o)
  );

  opunit_rdport #(.NSRC(NSRC), .DW(DW)) rd_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .arm      (issue_take),
    .cancel_i (cancel_i),
    .rd_gnt_i (rd_gnt_i),
    .src_i    (src_i),
    .rd_req   (rd_req_o),
    .rd_left  (rd_left),
    .rd_take  (rd_take),
    .opnd     (opnd)
  );

  opunit_alu #(.DW(DW)) alu_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .op_load (issue_take),
    .op_i    (op_i),
    .exec_go (exec_go),
    .opnd_a  (opnd[DW-1:0]),
    .opnd_b  (opnd[2*DW-1:DW]),
    .result  (wr_data_o)
  );

  assign bus_o = wr_take ? wr_data_o : '0;
endmodule

// File: rtl/opunit_ctrl_chk.sv
module opunit_ctrl_chk #(
  parameter int NSRC = 2,
  parameter int DW   = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            issue_i,
  input logic            cancel_i,
  input logic [NSRC-1:0] rd_gnt_i,
  input logic            wr_gnt_i,
  input logic            busy_o,
  input logic [NSRC-1:0] rd_req_o,
  input logic            wr_req_o,
  input logic [DW-1:0]   wr_data_o,
  input logic [DW-1:0]   bus_o,
  input logic            issue_take,
  input logic            exec_go
);
  logic seen_issue_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       seen_issue_q <= 1'b0;
    else if (issue_i) seen_issue_q <= 1'b1;
  end

  assert_no_req_before_issue_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_o != '0) |-> seen_issue_q);

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (rd_req_o == '0) && !wr_req_o);

  assert_issue_arms_R2: assert property (@(posedge clk) disable iff (!rst_n)
    issue_take |=> (rd_req_o == '1) && busy_o);

  assert_busy_blocks_issue_R2: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !issue_take);

  for (genvar gi = 0; gi < NSRC; gi++) begin : g_bit
    assert_rdreq_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req_o[gi] && !rd_gnt_i[gi] && !cancel_i |=> rd_req_o[gi]);

    assert_grant_drops_R4: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req_o[gi] && rd_gnt_i[gi] |=> !rd_req_o[gi]);
  end

  assert_exec_to_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    exec_go && !cancel_i |=> wr_req_o);

  assert_phases_disjoint_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !((rd_req_o != '0) && wr_req_o));

  assert_wrdata_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req_o && !wr_gnt_i && !cancel_i |=> wr_req_o && $stable(wr_data_o));

  assert_write_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req_o && wr_gnt_i && !cancel_i |=> !wr_req_o && !busy_o);

  assert_bus_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_req_o && wr_gnt_i) |-> (bus_o == '0));

  assert_cancel_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cancel_i |=> (rd_req_o == '0) && !wr_req_o && !busy_o);
endmodule

bind opunit_ctrl opunit_ctrl_chk #(.NSRC(NSRC), .DW(DW)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .issue_i    (issue_i),
  .cancel_i   (cancel_i),
  .rd_gnt_i   (rd_gnt_i),
  .wr_gnt_i   (wr_gnt_i),
  .busy_o     (busy_o),
  .rd_req_o   (rd_req_o),
  .wr_req_o   (wr_req_o),
  .wr_data_o  (wr_data_o),
  .bus_o      (bus_o),
  .issue_take (issue_take),
  .exec_go    (exec_go)
);

// File: tb/opunit_ctrl_tb.sv
`timescale 1ns/1ps
module opunit_ctrl_tb_top;
  localparam int NSRC = 2;
  localparam int DW   = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          issue = 1'b0;
  logic [1:0]    op = 2'd0;
  logic [DW-1:0] src_a = '0;
  logic [DW-1:0] src_b = '0;
  logic [1:0]    rd_gnt = 2'b00;
  logic          wr_gnt = 1'b0;
  logic          cancel = 1'b0;
  logic          busy;
  logic [1:0]    rd_req;
  logic          wr_req;
  logic [DW-1:0] wr_data;
  logic [DW-1:0] bus;

  int checks = 0;
  int errors = 0;
  logic [DW-1:0] exp_q[$];

  always #4 clk = ~clk;

  opunit_ctrl #(.NSRC(NSRC), .DW(DW)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .issue_i   (issue),
    .op_i      (op),
    .src_i     ({src_b, src_a}),
    .rd_gnt_i  (rd_gnt),
    .wr_gnt_i  (wr_gnt),
    .cancel_i  (cancel),
    .busy_o    (busy),
    .rd_req_o  (rd_req),
    .wr_req_o  (wr_req),
    .wr_data_o (wr_data),
    .bus_o     (bus)
  );

  function automatic logic [DW-1:0] model(input logic [1:0] o,
                                          input logic [DW-1:0] a,
                                          input logic [DW-1:0] b);
    logic [DW-1:0] r;
    if (o == 2'd0)      r = a + b;
    else if (o == 2'd1) r = a + ~b + 1'b1;
    else if (o == 2'd2) r = a;
    else                r = b;
    return r;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  // driver: present an issue and push the expected result
  task automatic do_issue(input logic [1:0] o, input logic [DW-1:0] a,
                          input logic [DW-1:0] b);
    exp_q.push_back(model(o, a, b));
    issue = 1'b1;
    op    = o;
    step();
    issue = 1'b0;
    chk("R2 rd_req after issue", rd_req, 2'b11);
    chk("R2 busy after issue", busy, 1);
  endtask

  task automatic grant(input logic [1:0] g, input logic [DW-1:0] a,
                       input logic [DW-1:0] b);
    src_a  = a;
    src_b  = b;
    rd_gnt = g;
    step();
    rd_gnt = 2'b00;
    src_a  = 16'hffff;
    src_b  = 16'hffff;
  endtask

  task automatic finish_write();
    wr_gnt = 1'b1;
    step();
    wr_gnt = 1'b0;
    chk("R8 wr_req after grant", wr_req, 0);
    chk("R8 busy after grant", busy, 0);
  endtask

  // monitor: compare the result bus against the scoreboard queue
  always @(negedge clk) begin
    if (rst_n && wr_gnt) begin
      if (wr_req && !cancel) begin
        if (exp_q.size() == 0) begin
          checks++;
          errors++;
          $display("FAIL R8 unexpected write actual=%h expected=none", bus);
        end else begin
          chk("R8 bus value", bus, exp_q.pop_front());
        end
      end else begin
        chk("R10 bus quiet without write request", bus, 0);
      end
    end
  end

  initial begin
    #(8 * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    step();
    // R1 reset state
    chk("R1 rd_req reset", rd_req, 0);
    chk("R1 wr_req reset", wr_req, 0);
    chk("R1 busy reset", busy, 0);

    // R1 R10 grants while idle are ignored
    rd_gnt = 2'b11;
    wr_gnt = 1'b1;
    step();
    rd_gnt = 2'b00;
    wr_gnt = 1'b0;
    chk("R1 rd_req before issue", rd_req, 0);
    chk("R10 wr_req idle grant", wr_req, 0);
    chk("R10 busy idle grant", busy, 0);

    // ADD, both operands granted together
    do_issue(2'd0, 16'h0005, 16'h0005);
    step();
    step();
    chk("R3 requests held", rd_req, 2'b11);
    grant(2'b11, 16'h0005, 16'h0005);
    chk("R4 both dropped", rd_req, 0);
    chk("R6 no write during exec", wr_req, 0);
    step();
    chk("R6 write request", wr_req, 1);
    chk("R5 R6 add result", wr_data, 16'h000a);
    src_a = 16'h1111;
    step();
    chk("R7 write held", wr_req, 1);
    chk("R7 data stable", wr_data, 16'h000a);
    finish_write();

    // SUB, B granted first, then masked all-ones grant
    do_issue(2'd1, 16'h1234, 16'h0235);
    grant(2'b10, 16'h0000, 16'h0235);
    chk("R4 only bit1 dropped", rd_req, 2'b01);
    issue = 1'b1;
    op    = 2'd3;
    step();
    issue = 1'b0;
    chk("R2 issue ignored while busy", rd_req, 2'b01);
    wr_gnt = 1'b1;
    step();
    wr_gnt = 1'b0;
    chk("R10 write grant in read phase", wr_req, 0);
    chk("R3 bit0 still held", rd_req, 2'b01);
    grant(2'b11, 16'h1234, 16'hdead);
    chk("R4 masked grant clears", rd_req, 0);
    step();
    chk("R5 R6 sub result", wr_data, 16'h0fff);
    finish_write();

    // cancel during the read phase, then issue on the next cycle
    do_issue(2'd2, 16'h4444, 16'h0000);
    grant(2'b01, 16'h4444, 16'h0000);
    cancel = 1'b1;
    step();
    cancel = 1'b0;
    void'(exp_q.pop_back());
    chk("R9 rd_req cleared", rd_req, 0);
    chk("R9 busy cleared", busy, 0);
    issue = 1'b1;
    op    = 2'd0;
    step();
    issue = 1'b0;
    chk("R2 issue refused after pending read", busy, 0);
    chk("R2 no requests after refused issue", rd_req, 0);

    // cancel beats a simultaneous issue
    issue  = 1'b1;
    cancel = 1'b1;
    step();
    issue  = 1'b0;
    cancel = 1'b0;
    chk("R9 cancel beats issue", busy, 0);

    // cancel while the write is waiting
    do_issue(2'd3, 16'h0001, 16'hbeef);
    grant(2'b11, 16'h0001, 16'hbeef);
    step();
    chk("R6 pass B result", wr_data, 16'hbeef);
    cancel = 1'b1;
    wr_gnt = 1'b1;
    step();
    cancel = 1'b0;
    wr_gnt = 1'b0;
    void'(exp_q.pop_back());
    chk("R9 wr_req cleared", wr_req, 0);
    chk("R9 busy cleared after write cancel", busy, 0);

    // PASS_A then an immediate back-to-back ADD with wraparound
    do_issue(2'd2, 16'h7777, 16'h0001);
    grant(2'b01, 16'h7777, 16'h0000);
    grant(2'b10, 16'h0000, 16'h0001);
    step();
    chk("R6 pass A result", wr_data, 16'h7777);
    finish_write();
    do_issue(2'd0, 16'hfff0, 16'h0020);
    grant(2'b11, 16'hfff0, 16'h0020);
    step();
    chk("R6 add wraps", wr_data, 16'h0010);
    finish_write();

    step();
    chk("R8 scoreboard drained", exp_q.size(), 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule